// File: doc/BRIEF.md
# Double-Buffered Compare PWM Generator

This block is an up-counting PWM time base that drives one raw output from two separate compare events. One compare match raises the output and the other lowers it. Software may rewrite the period, the two edge compares and a sync compare at any moment. Each write goes into a holding copy, and all holding copies move into the working copies together, in the cycle the counter sits at zero. A duty or period change made part-way through a cycle therefore takes effect from the next cycle start. It cannot cut a cycle short, drop an edge or add an edge.

A third compare value marks a point in the cycle where the block emits a one-clock sync pulse for a neighbouring time base. The opposite direction is also supported. When phase loading is enabled, a pulse on the sync input forces the counter to a programmed phase value, so several such blocks can run locked together at chosen offsets.

Top module: `pwm_shadow_gen`

## Requirements
- R1: The counter runs 0, 1, ... up to the working period, then returns to 0. A working period of 0 holds the counter at 0. A counter value above the period, which only a phase load can produce, is followed by 0.
- R2: A period written through `wr_sel` = 0 does not shorten or stretch the running cycle. It becomes the working period when the counter next reaches 0.
- R3: Writes to compare A (`wr_sel` = 1), compare B (`wr_sel` = 2) and the sync compare (`wr_sel` = 3) change only the holding copies. The working copies change only in a clock where the counter equals 0. Codes 5 to 7 are ignored.
- R4: A write that lands in the same clock as the zero-count transfer leaves the working copy with the previous holding value, whole. The written value becomes active at the following zero.
- R5: `pwm_out` goes high one clock after the counter equals working compare A.
- R6: `pwm_out` goes low one clock after the counter equals working compare B.
- R7: When compare A and compare B match in the same clock, the output goes low.
- R8: A compare value larger than the working period never matches. With no match, `pwm_out` keeps its level.
- R9: `sync_out` is high for exactly one clock, one clock after the counter equals the working sync compare. It stays low if that compare exceeds the period or if the period is 0.
- R10: The phase register is written directly with `wr_sel` = 4. With `phase_en` high, a `sync_in` clock puts the phase value in the counter on the next clock. With `phase_en` low, `sync_in` is ignored.
- R11: Reset is synchronous and active high. It clears the counter, `pwm_out`, `sync_out` and the phase to 0, sets the period to 15 and sets every compare to all-ones, so no compare can match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 period, 1 compare A, 2 compare B, 3 sync compare, 4 phase |
| wr_data | input | 16 | Write data |
| phase_en | input | 1 | Allows `sync_in` to load the phase into the counter |
| sync_in | input | 1 | External sync pulse |
| pwm_out | output | 1 | Raw PWM output |
| sync_out | output | 1 | One-clock sync pulse at the sync compare point |
| cnt_out | output | 16 | Current counter value |

## Verification
Two events can fall in the same clock: a software write and the zero-count transfer of holding copies to working copies. The bench provokes this by waiting until it sees the counter at 0 and writing a new compare A in that clock. It then checks the output level at a fixed count in two consecutive cycles. The old setting must hold through the first cycle and the new setting through the second. The coincidence of the two edge compares is covered separately: a configuration with equal A and B must give an output that is never high.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    localparam int unsigned PWM_W = 16;

    typedef logic [PWM_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        SEL_PRD = 3'd0,
        SEL_CA  = 3'd1,
        SEL_CB  = 3'd2,
        SEL_CC  = 3'd3,
        SEL_PHS = 3'd4
    } reg_sel_e;

    typedef struct packed {
        cnt_t prd;
        cnt_t ca;
        cnt_t cb;
        cnt_t cc;
    } cfg_t;

    typedef struct packed {
        logic set_hit;
        logic clr_hit;
        logic sync_hit;
    } evt_t;

    // A compare point counts only when it lies inside the cycle.
    function automatic logic cmp_match(cnt_t cnt, cnt_t cmpv, cnt_t prd);
        return (cnt == cmpv) && (cmpv <= prd);
    endfunction

    // Returns the holding set with one field replaced.
    function automatic cfg_t cfg_write(cfg_t cur, reg_sel_e sel, cnt_t d);
        cfg_t nxt;
        nxt = cur;
        case (sel)
            SEL_PRD: nxt.prd = d;
            SEL_CA:  nxt.ca  = d;
            SEL_CB:  nxt.cb  = d;
            SEL_CC:  nxt.cc  = d;
            default: nxt     = cur;
        endcase
        return nxt;
    endfunction

    function automatic cfg_t cfg_reset(cnt_t prd);
        cfg_t r;
        r.prd = prd;
        r.ca  = '1;
        r.cb  = '1;
        r.cc  = '1;
        return r;
    endfunction

endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwmgen_pkg::*;
#(
    parameter int unsigned RST_PRD = 15
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e wr_sel,
    input  cnt_t     wr_data,
    input  logic     load_zero,
    output cfg_t     act,
    output cnt_t     phase
);

    localparam cnt_t RST_PRD_C = cnt_t'(RST_PRD);

    cfg_t shd_q;
    cfg_t act_q;
    cnt_t phs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_q <= cfg_reset(RST_PRD_C);
            act_q <= cfg_reset(RST_PRD_C);
            phs_q <= '0;
        end else begin
            // Transfer uses the holding set as it stood before this clock.
            if (load_zero) begin
                act_q <= shd_q;
            end
            if (wr_en) begin
                if (wr_sel == SEL_PHS) begin
                    phs_q <= wr_data;
                end else begin
                    shd_q <= cfg_write(shd_q, wr_sel, wr_data);
                end
            end
        end
    end

    assign act   = act_q;
    assign phase = phs_q;

    // R3: working copies move only at a zero count
    a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
        !load_zero |=> $stable(act_q));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t prd,
    input  cnt_t phase,
    input  logic phase_en,
    input  logic sync_in,
    output cnt_t cnt,
    output logic at_zero
);

    cnt_t cnt_q;
    logic phs_load;

    assign phs_load = phase_en && sync_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (phs_load) begin
            cnt_q <= phase;
        end else if (cnt_q >= prd) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign at_zero = (cnt_q == '0);

    // R1: the top of the cycle is followed by zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == prd && !phs_load) |=> cnt_q == '0);

    // R1: an out-of-range count returns to zero
    a_r1_range: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > prd && !phs_load) |=> cnt_q == '0);

    // R10: phase load lands on the next clock
    a_r10_phase_load: assert property (@(posedge clk) disable iff (rst)
        phs_load |=> cnt_q == $past(phase));

endmodule

// File: rtl/pwm_event_unit.sv
module pwm_event_unit
    import pwmgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t cnt,
    input  cfg_t act,
    output logic pwm_out,
    output logic sync_out
);

    evt_t ev;
    logic pwm_q;
    logic sync_q;

    always_comb begin
        ev.set_hit  = cmp_match(cnt, act.ca, act.prd);
        ev.clr_hit  = cmp_match(cnt, act.cb, act.prd);
        ev.sync_hit = cmp_match(cnt, act.cc, act.prd) && (act.prd != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            if (ev.clr_hit) begin
                pwm_q <= 1'b0;
            end else if (ev.set_hit) begin
                pwm_q <= 1'b1;
            end
            sync_q <= ev.sync_hit;
        end
    end

    assign pwm_out  = pwm_q;
    assign sync_out = sync_q;

    // R7: equal match points always end low
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (cnt == act.ca && cnt == act.cb) |=> !pwm_q);

    // R8: compare points beyond the period leave the level alone
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (act.ca > act.prd && act.cb > act.prd) |=> $stable(pwm_q));

    // R6: a compare B match inside the cycle lowers the output
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (cnt == act.cb && act.cb <= act.prd) |=> !pwm_q);

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
    import pwmgen_pkg::*;
#(
    parameter int unsigned RST_PRD = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [PWM_W-1:0] wr_data,
    input  logic             phase_en,
    input  logic             sync_in,
    output logic             pwm_out,
    output logic             sync_out,
    output logic [PWM_W-1:0] cnt_out
);

    cfg_t act;
    cnt_t phase;
    cnt_t cnt;
    logic at_zero;

    pwm_shadow_bank #(.RST_PRD(RST_PRD)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (reg_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .load_zero (at_zero),
        .act       (act),
        .phase     (phase)
    );

    pwm_timebase tb_i (
        .clk      (clk),
        .rst      (rst),
        .prd      (act.prd),
        .phase    (phase),
        .phase_en (phase_en),
        .sync_in  (sync_in),
        .cnt      (cnt),
        .at_zero  (at_zero)
    );

    pwm_event_unit ev_i (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .act      (act),
        .pwm_out  (pwm_out),
        .sync_out (sync_out)
    );

    assign cnt_out = cnt;

    // R9: the sync pulse lasts one clock unless a phase load repeats the match
    a_r9_one_clock: assert property (@(posedge clk) disable iff (rst)
        (sync_out && !$past(sync_in && phase_en)) |=> !sync_out);

endmodule

// File: tb/pwm_shadow_gen_tb_top.sv
module pwm_shadow_gen_tb_top;

    localparam int CLK_P = 10;
    localparam int NV = 7;
    // period, compare A, compare B, sync compare, expected high clocks, expected sync pulses
    localparam int VEC [0:NV-1][0:5] = '{
        '{ 9,  2,  7,  0,  5, 1},
        '{ 9,  7,  2,  5,  5, 1},
        '{ 9,  3,  3,  9,  0, 1},
        '{ 9, 12,  4,  3,  0, 1},
        '{ 9,  1, 15, 10, 10, 0},
        '{ 4,  0,  4,  2,  4, 1},
        '{20,  5, 15, 20, 10, 1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        phase_en = 1'b0;
    logic        sync_in = 1'b0;
    logic        pwm_out;
    logic        sync_out;
    logic [15:0] cnt_out;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    pwm_shadow_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .phase_en (phase_en),
        .sync_in  (sync_in),
        .pwm_out  (pwm_out),
        .sync_out (sync_out),
        .cnt_out  (cnt_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        wr_en   = 1'b1;
        wr_sel  = 3'(sel);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(cnt_out) != v);
    endtask

    task automatic configure(input int p, input int a, input int b, input int c);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wr(0, p);
        wr(1, a);
        wr(2, b);
        wr(3, c);
        repeat (80) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int mx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11 cnt after reset", int'(cnt_out), 0);
        chk("R11 pwm after reset", int'(pwm_out), 0);
        chk("R11 sync after reset", int'(sync_out), 0);
        wait_cnt(15);
        @(negedge clk);
        chk("R11 default period wraps after 15", int'(cnt_out), 0);
        chk("R11 compares idle, output low", int'(pwm_out), 0);

        // Vector table: R5 R6 R7 R8 R9 over one full cycle
        for (int i = 0; i < NV; i++) begin
            int hi;
            int sy;
            hi = 0;
            sy = 0;
            configure(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            for (int k = 0; k <= VEC[i][0]; k++) begin
                @(negedge clk);
                hi += int'(pwm_out);
                sy += int'(sync_out);
            end
            chk($sformatf("R5 R6 R7 R8 high clocks vec%0d", i), hi, VEC[i][4]);
            chk($sformatf("R9 sync pulses vec%0d", i), sy, VEC[i][5]);
        end

        // R5 and R6 edge timing
        configure(9, 2, 7, 5);
        wait_cnt(2);
        chk("R5 low at the match clock", int'(pwm_out), 0);
        @(negedge clk);
        chk("R5 high one clock after A match", int'(pwm_out), 1);
        wait_cnt(8);
        chk("R6 low one clock after B match", int'(pwm_out), 0);

        // R9 pulse placement
        wait_cnt(5);
        chk("R9 no pulse at match clock", int'(sync_out), 0);
        @(negedge clk);
        chk("R9 pulse one clock later", int'(sync_out), 1);
        @(negedge clk);
        chk("R9 pulse one clock wide", int'(sync_out), 0);

        // R3: mid-cycle compare B write leaves the running cycle alone
        wait_cnt(3);
        wr(2, 4);
        wait_cnt(5);
        chk("R3 old B still active this cycle", int'(pwm_out), 1);
        wait_cnt(5);
        chk("R3 new B active next cycle", int'(pwm_out), 0);

        // R4: write in the transfer clock (A=2,B=4 now active)
        wait_cnt(0);
        wr(1, 5);
        wait_cnt(7);
        chk("R4 old A kept at coinciding write", int'(pwm_out), 0);
        wait_cnt(7);
        chk("R4 new A from following zero", int'(pwm_out), 1);

        // R3: unused select codes have no effect
        wr(5, 1);
        wr(6, 1);
        wr(7, 1);
        repeat (25) @(negedge clk);
        wait_cnt(7);
        chk("R3 codes 5-7 ignored", int'(pwm_out), 1);

        // R2: period change waits for the zero count
        configure(9, 2, 7, 5);
        wait_cnt(3);
        wr(0, 5);
        mx = 0;
        while (int'(cnt_out) != 0) begin
            if (int'(cnt_out) > mx) mx = int'(cnt_out);
            @(negedge clk);
        end
        chk("R2 running cycle keeps old period", mx, 9);
        mx = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (int'(cnt_out) > mx) mx = int'(cnt_out);
        end
        chk("R2 new period after zero", mx, 5);

        // R10: phase load
        configure(9, 2, 7, 5);
        wr(4, 7);
        phase_en = 1'b1;
        wait_cnt(2);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R10 counter loaded with phase", int'(cnt_out), 7);
        phase_en = 1'b0;
        wait_cnt(2);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R10 sync ignored without enable", int'(cnt_out), 3);

        // R1: phase above period returns to zero
        wr(4, 12);
        phase_en = 1'b1;
        wait_cnt(4);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        phase_en = 1'b0;
        chk("R10 phase above period loaded", int'(cnt_out), 12);
        @(negedge clk);
        chk("R1 out-of-range count returns to zero", int'(cnt_out), 0);

        // R1: period zero holds the counter
        configure(0, 30, 30, 30);
        chk("R1 period zero holds counter", int'(cnt_out), 0);
        @(negedge clk);
        chk("R1 period zero still zero", int'(cnt_out), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule